// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This unit sits beside a processor core and performs the architectural state switch that happens when the core takes an interrupt or executes a trap instruction. The core presents its live status word, program counter, vector base and general register 15 on input ports. The interrupt controller signals an accepted request with a one-cycle strobe and an event code. The decode stage raises a trap request for the same purpose.

One clock edge after a request is taken, the unit drives a one-cycle valid strobe. With it come the new program counter and the new status word. It also holds the shadow copies of the old status word, the old program counter and R15. The event code goes into one of two separate registers: one for interrupts and one for traps. Interrupts and traps use different vector offsets and store the return address differently.

A request that arrives while the block bit of the live status word is already set is a protocol violation. It is not taken. Instead, an error strobe is raised and all held state stays as it was.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `ent_valid` and `ent_err` are 0, and every held output (`new_pc`, `new_sr`, `sav_sr`, `sav_pc`, `sav_gr`, `int_code`, `exc_code`, `ent_is_trap`) is 0.
- R2: An interrupt strobe taken with status bit 28 (block) clear produces `ent_valid`=1 exactly one cycle later, with `new_pc` = `cur_vbr` + 0x600 (modulo 2^32) and `ent_is_trap`=0.
- R3: On any taken entry, `sav_sr`, `sav_gr` and (for interrupts) `sav_pc` receive the `cur_sr`, `cur_r15` and `cur_pc` values presented with the request.
- R4: `new_sr` equals `cur_sr` with bits 30 (privileged), 29 (bank) and 28 (block) forced to 1. All other bits, including the interrupt mask at [7:4], are unchanged.
- R5: A taken interrupt loads `irq_code` into `int_code` and leaves `exc_code` unchanged.
- R6: A taken trap loads 0x160 into `exc_code`, drives `new_pc` = `cur_vbr` + 0x100 and `ent_is_trap`=1, and leaves `int_code` unchanged.
- R7: A taken trap stores `cur_pc` + 2 (modulo 2^32) into `sav_pc`.
- R8: A request (interrupt or trap) presented while `cur_sr` bit 28 is 1 gives `ent_err`=1 and `ent_valid`=0 one cycle later, and leaves every held output unchanged.
- R9: When the interrupt strobe and the trap request occur in the same cycle, only the interrupt is taken, and `exc_code` keeps its old value.
- R10: In a cycle with no request, the next cycle shows `ent_valid`=0 and `ent_err`=0, and all held outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_accept | input | 1 | One-cycle interrupt accept strobe |
| irq_code | input | 12 | Interrupt event code |
| trap_req | input | 1 | One-cycle trap request |
| cur_sr | input | 32 | Live status word |
| cur_pc | input | 32 | Live program counter |
| cur_vbr | input | 32 | Vector base |
| cur_r15 | input | 32 | Live general register 15 |
| ent_valid | output | 1 | Entry completed this cycle |
| ent_err | output | 1 | Request refused because block bit was set |
| ent_is_trap | output | 1 | Last entry was a trap |
| new_pc | output | 32 | Redirect target |
| new_sr | output | 32 | Status word for the handler |
| sav_sr | output | 32 | Saved status word |
| sav_pc | output | 32 | Saved return address |
| sav_gr | output | 32 | Saved R15 |
| int_code | output | 12 | Interrupt event register |
| exc_code | output | 12 | Exception event register |

## Verification
Every held output is a register that changes only on a taken entry. A wrong selection therefore shows up on the next edge: a missing or extra valid pulse, a wrong vector, or an event code in the wrong register. It then stays visible until the next entry overwrites it. A refused request that leaks a write shows at once as a changed save register next to the error strobe. Because of this, each entry is compared field by field in the cycle after its request, and also in the idle cycles that follow.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   typedef enum logic [1:0] {
      ENT_NONE    = 2'd0,
      ENT_IRQ     = 2'd1,
      ENT_TRAP    = 2'd2,
      ENT_BLOCKED = 2'd3
   } entry_e;

   localparam int N_FORCED = 3;
endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
   import exc_entry_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int BL_POS = 28
) (
   input  logic            irq_accept,
   input  logic            trap_req,
   input  logic [XLEN-1:0] cur_sr,
   output entry_e          sel
);
   logic blocked;
   assign blocked = cur_sr[BL_POS];

   always_comb begin
      sel = ENT_NONE;
      if (irq_accept || trap_req) begin
         if (blocked)         sel = ENT_BLOCKED;
         else if (irq_accept) sel = ENT_IRQ;
         else                 sel = ENT_TRAP;
      end
   end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
   import exc_entry_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int MD_POS      = 30,
   parameter int RB_POS      = 29,
   parameter int BL_POS      = 28,
   parameter int IRQ_OFFSET  = 'h600,
   parameter int TRAP_OFFSET = 'h100,
   parameter int INSN_BYTES  = 2
) (
   input  entry_e          sel,
   input  logic [XLEN-1:0] cur_sr,
   input  logic [XLEN-1:0] cur_pc,
   input  logic [XLEN-1:0] cur_vbr,
   output logic [XLEN-1:0] nxt_pc,
   output logic [XLEN-1:0] nxt_sr,
   output logic [XLEN-1:0] nxt_spc
);
   localparam logic [XLEN-1:0] IRQ_OFF  = XLEN'(IRQ_OFFSET);
   localparam logic [XLEN-1:0] TRAP_OFF = XLEN'(TRAP_OFFSET);
   localparam logic [XLEN-1:0] STEP     = XLEN'(INSN_BYTES);
   localparam int FORCED_POS [N_FORCED] = '{MD_POS, RB_POS, BL_POS};

   logic [XLEN-1:0] force_mask;

   for (genvar g = 0; g < N_FORCED; g++) begin : g_force
      if (FORCED_POS[g] < 0 || FORCED_POS[g] >= XLEN)
         $error("forced status bit out of range");
      assign force_mask[FORCED_POS[g]] = 1'b1;
   end

   for (genvar b = 0; b < XLEN; b++) begin : g_fill
      if (b != MD_POS && b != RB_POS && b != BL_POS) begin : g_zero
         assign force_mask[b] = 1'b0;
      end
   end

   assign nxt_sr  = cur_sr | force_mask;
   assign nxt_pc  = cur_vbr + ((sel == ENT_TRAP) ? TRAP_OFF : IRQ_OFF);
   assign nxt_spc = (sel == ENT_TRAP) ? (cur_pc + STEP) : cur_pc;
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CODE_W    = 12,
   parameter int TRAP_CODE = 'h160
) (
   input  logic              clk,
   input  logic              rst_n,
   input  entry_e            sel,
   input  logic [CODE_W-1:0] irq_code,
   input  logic [XLEN-1:0]   cur_sr,
   input  logic [XLEN-1:0]   cur_r15,
   input  logic [XLEN-1:0]   nxt_pc,
   input  logic [XLEN-1:0]   nxt_sr,
   input  logic [XLEN-1:0]   nxt_spc,
   output logic              ent_valid,
   output logic              ent_err,
   output logic              ent_is_trap,
   output logic [XLEN-1:0]   new_pc,
   output logic [XLEN-1:0]   new_sr,
   output logic [XLEN-1:0]   sav_sr,
   output logic [XLEN-1:0]   sav_pc,
   output logic [XLEN-1:0]   sav_gr,
   output logic [CODE_W-1:0] int_code,
   output logic [CODE_W-1:0] exc_code
);
   localparam logic [CODE_W-1:0] TRAP_EVT = CODE_W'(TRAP_CODE);

   logic taking;
   assign taking = (sel == ENT_IRQ) || (sel == ENT_TRAP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid   <= 1'b0;
         ent_err     <= 1'b0;
         ent_is_trap <= 1'b0;
         new_pc      <= '0;
         new_sr      <= '0;
         sav_sr      <= '0;
         sav_pc      <= '0;
         sav_gr      <= '0;
         int_code    <= '0;
         exc_code    <= '0;
      end else begin
         ent_valid <= taking;
         ent_err   <= (sel == ENT_BLOCKED);
         if (taking) begin
            ent_is_trap <= (sel == ENT_TRAP);
            new_pc      <= nxt_pc;
            new_sr      <= nxt_sr;
            sav_sr      <= cur_sr;
            sav_pc      <= nxt_spc;
            sav_gr      <= cur_r15;
         end
         if (sel == ENT_IRQ)  int_code <= irq_code;
         if (sel == ENT_TRAP) exc_code <= TRAP_EVT;
      end
   end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int CODE_W      = 12,
   parameter int MD_POS      = 30,
   parameter int RB_POS      = 29,
   parameter int BL_POS      = 28,
   parameter int IRQ_OFFSET  = 'h600,
   parameter int TRAP_OFFSET = 'h100,
   parameter int TRAP_CODE   = 'h160,
   parameter int INSN_BYTES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_accept,
   input  logic [CODE_W-1:0] irq_code,
   input  logic              trap_req,
   input  logic [XLEN-1:0]   cur_sr,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [XLEN-1:0]   cur_vbr,
   input  logic [XLEN-1:0]   cur_r15,
   output logic              ent_valid,
   output logic              ent_err,
   output logic              ent_is_trap,
   output logic [XLEN-1:0]   new_pc,
   output logic [XLEN-1:0]   new_sr,
   output logic [XLEN-1:0]   sav_sr,
   output logic [XLEN-1:0]   sav_pc,
   output logic [XLEN-1:0]   sav_gr,
   output logic [CODE_W-1:0] int_code,
   output logic [CODE_W-1:0] exc_code
);
   if (MD_POS == RB_POS || RB_POS == BL_POS || MD_POS == BL_POS)
      $error("status bit positions must differ");
   if (CODE_W < 9 || TRAP_CODE >= (1 << CODE_W))
      $error("event code width too small");
   if (INSN_BYTES <= 0)
      $error("instruction size must be positive");

   entry_e          sel;
   logic [XLEN-1:0] nxt_pc, nxt_sr, nxt_spc;

   exc_entry_arb #(.XLEN(XLEN), .BL_POS(BL_POS)) u_arb (
      .irq_accept(irq_accept), .trap_req(trap_req), .cur_sr(cur_sr), .sel(sel));

   exc_entry_calc #(
      .XLEN(XLEN), .MD_POS(MD_POS), .RB_POS(RB_POS), .BL_POS(BL_POS),
      .IRQ_OFFSET(IRQ_OFFSET), .TRAP_OFFSET(TRAP_OFFSET), .INSN_BYTES(INSN_BYTES)
   ) u_calc (
      .sel(sel), .cur_sr(cur_sr), .cur_pc(cur_pc), .cur_vbr(cur_vbr),
      .nxt_pc(nxt_pc), .nxt_sr(nxt_sr), .nxt_spc(nxt_spc));

   exc_entry_regs #(.XLEN(XLEN), .CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(sel), .irq_code(irq_code),
      .cur_sr(cur_sr), .cur_r15(cur_r15),
      .nxt_pc(nxt_pc), .nxt_sr(nxt_sr), .nxt_spc(nxt_spc),
      .ent_valid(ent_valid), .ent_err(ent_err), .ent_is_trap(ent_is_trap),
      .new_pc(new_pc), .new_sr(new_sr), .sav_sr(sav_sr), .sav_pc(sav_pc),
      .sav_gr(sav_gr), .int_code(int_code), .exc_code(exc_code));

   // R2: accepted interrupt redirects to vector base plus interrupt offset
   p_irq_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_accept && !cur_sr[BL_POS]) |=>
         (ent_valid && !ent_is_trap && new_pc == $past(cur_vbr) + XLEN'(IRQ_OFFSET)));

   // R3: register copies
   p_save_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_accept && !cur_sr[BL_POS]) |=>
         (sav_pc == $past(cur_pc) && sav_gr == $past(cur_r15) && sav_sr == $past(cur_sr)));

   // R4: handler status has the three control bits set
   p_forced_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid |-> (new_sr[MD_POS] && new_sr[RB_POS] && new_sr[BL_POS]));

   // R7: trap return address skips the trap instruction
   p_trap_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !irq_accept && !cur_sr[BL_POS]) |=>
         (ent_is_trap && sav_pc == $past(cur_pc) + XLEN'(INSN_BYTES)));

   // R8: refused request leaves the save registers alone
   p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_accept || trap_req) && cur_sr[BL_POS]) |=>
         (ent_err && !ent_valid && $stable(sav_pc) && $stable(sav_sr) && $stable(new_pc)));

   // R9: simultaneous requests keep the exception event register
   p_irq_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_accept && trap_req && !cur_sr[BL_POS]) |=> $stable(exc_code));

   // R10: quiet cycle produces no strobe
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_accept && !trap_req) |=> (!ent_valid && !ent_err));
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_accept = 1'b0;
   logic [11:0] irq_code = '0;
   logic        trap_req = 1'b0;
   logic [31:0] cur_sr = '0, cur_pc = '0, cur_vbr = '0, cur_r15 = '0;
   logic        ent_valid, ent_err, ent_is_trap;
   logic [31:0] new_pc, new_sr, sav_sr, sav_pc, sav_gr;
   logic [11:0] int_code, exc_code;

   int n_checks = 0;
   int n_errors = 0;

   always #2 clk = ~clk;

   exc_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .irq_accept(irq_accept), .irq_code(irq_code),
      .trap_req(trap_req), .cur_sr(cur_sr), .cur_pc(cur_pc), .cur_vbr(cur_vbr),
      .cur_r15(cur_r15), .ent_valid(ent_valid), .ent_err(ent_err),
      .ent_is_trap(ent_is_trap), .new_pc(new_pc), .new_sr(new_sr),
      .sav_sr(sav_sr), .sav_pc(sav_pc), .sav_gr(sav_gr),
      .int_code(int_code), .exc_code(exc_code));

   typedef struct {
      logic        valid, err, trap;
      logic [31:0] pc, sr, ssr, spc, sgr;
      logic [11:0] ievt, eevt;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   exp_t m;
   bit   monitor_on = 1'b0;

   task automatic chk(input string tag, input string fld, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
      end
   endtask

   task automatic step(input string tag, input bit irq, input logic [11:0] code,
                       input bit trap, input logic [31:0] sr, input logic [31:0] pc,
                       input logic [31:0] vbr, input logic [31:0] r15);
      exp_t e;
      irq_accept = irq; irq_code = code; trap_req = trap;
      cur_sr = sr; cur_pc = pc; cur_vbr = vbr; cur_r15 = r15;
      e = m;
      e.tag = tag;
      e.valid = 1'b0;
      e.err = 1'b0;
      if ((irq || trap) && sr[28]) begin
         e.err = 1'b1;
      end else if (irq || trap) begin
         e.valid = 1'b1;
         e.trap  = !irq;
         e.sr    = sr | 32'h7000_0000;
         e.ssr   = sr;
         e.sgr   = r15;
         if (irq) begin
            e.pc = vbr + 32'h600; e.spc = pc; e.ievt = code;
         end else begin
            e.pc = vbr + 32'h100; e.spc = pc + 32'd2; e.eevt = 12'h160;
         end
      end
      m = e;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      #1;
      if (monitor_on && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk(e.tag, "valid", 32'(ent_valid), 32'(e.valid));
         chk(e.tag, "err", 32'(ent_err), 32'(e.err));
         chk(e.tag, "is_trap", 32'(ent_is_trap), 32'(e.trap));
         chk(e.tag, "new_pc", new_pc, e.pc);
         chk(e.tag, "new_sr", new_sr, e.sr);
         chk(e.tag, "sav_sr", sav_sr, e.ssr);
         chk(e.tag, "sav_pc", sav_pc, e.spc);
         chk(e.tag, "sav_gr", sav_gr, e.sgr);
         chk(e.tag, "int_code", 32'(int_code), 32'(e.ievt));
         chk(e.tag, "exc_code", 32'(exc_code), 32'(e.eevt));
      end
   end

   initial begin
      #(200000 * 4);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      m = '{valid: 1'b0, err: 1'b0, trap: 1'b0, pc: '0, sr: '0, ssr: '0, spc: '0,
            sgr: '0, ievt: '0, eevt: '0, tag: "R1"};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state visible before any request
      chk("R1", "valid", 32'(ent_valid), 32'd0);
      chk("R1", "err", 32'(ent_err), 32'd0);
      chk("R1", "new_pc", new_pc, 32'd0);
      chk("R1", "sav_pc", sav_pc, 32'd0);
      chk("R1", "codes", {int_code, exc_code}, 32'd0);
      monitor_on = 1'b1;

      step("R10", 0, 12'h0, 0, 32'h0, 32'h100, 32'h8C00_0000, 32'h1);
      // R2 R3 R4 R5: interrupt with mask field set
      step("R2", 1, 12'h320, 0, 32'h0000_00F1, 32'h8C01_0A00, 32'h8C00_0000, 32'h8CFF_FFF0);
      step("R10", 0, 12'h0, 0, 32'h0000_0000, 32'h1234, 32'h0, 32'h0);
      // R6 R7: trap
      step("R6", 0, 12'h0, 1, 32'h4000_0030, 32'h8C02_0002, 32'hA000_0000, 32'h0C00_1000);
      step("R10", 0, 12'h3A0, 0, 32'h0, 32'h0, 32'h0, 32'h0);
      // R8: blocked interrupt, then blocked trap
      step("R8", 1, 12'h600, 0, 32'h1000_0000, 32'hDEAD_0000, 32'h1111_0000, 32'h5555_5555);
      step("R8", 0, 12'h0, 1, 32'h7000_00F0, 32'hBEEF_0000, 32'h2222_0000, 32'h6666_6666);
      // R9: both requests together
      step("R9", 1, 12'h400, 1, 32'h0000_0040, 32'h0000_2000, 32'h0C00_0000, 32'h0000_7777);
      // R3 R4: back-to-back interrupts, different patterns
      step("R3", 1, 12'h720, 0, 32'hA5A5_0F0F & 32'hEFFF_FFFF, 32'h1357_9BDE, 32'h0000_0100, 32'hFFFF_0000);
      step("R4", 1, 12'h560, 0, 32'h8000_0001, 32'h2468_ACE0, 32'hFFFF_FC00, 32'h0000_FFFF);
      // R7: trap with wrapping return address and vector
      step("R7", 0, 12'h0, 1, 32'h0000_0000, 32'hFFFF_FFFE, 32'hFFFF_FF80, 32'h0000_0042);
      step("R5", 1, 12'hFE0, 0, 32'h2000_0000, 32'h0000_0400, 32'h0000_1000, 32'h0000_0001);
      step("R10", 0, 12'h0, 0, 32'h0, 32'h0, 32'h0, 32'h0);
      step("R10", 0, 12'h0, 0, 32'h0, 32'h0, 32'h0, 32'h0);
      @(negedge clk);
      monitor_on = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule